// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block holds a small set of event counters that watch a DRAM controller. The controller supplies a vector of single-cycle event pulses, and each pulse line is identified by its index, the event code. Counter 0 counts only clock cycles. It also acts as the master timebase for the whole bank. The other counters each pick one event code and count the cycles in which that pulse is high.

Software programs and reads the bank through a plain register port with valid, write, address and data signals. Every counter has a control word and a read-only count word. Read data comes back one cycle after the request, qualified by a valid strobe.

When the cycle counter wraps, it freezes the whole bank and raises a level interrupt. Software then reads the counts and restarts the timebase. An event counter that reaches its limit saturates and sets a sticky flag. It does not interrupt.

Top module: `memc_perf_bank`

## Requirements
- R1: The control word of counter n is at byte offset 0x00+4n. Its count is read at offset 0x20+4n. Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request. Control word layout: bit 0 is the overflow flag, bit 1 is clear (active low), bit 2 is enable, and bits 31:24 are the event select.
- R2: The cycle counter (counter 0) increments once per clock while it is enabled, its clear bit is 1 and its overflow flag is 0. Its event select field always reads 0.
- R3: When the cycle counter increments past its maximum, it wraps to 0, sets its overflow flag and asserts `irq_o`.
- R4: While the cycle counter is disabled, held in clear, or overflowed, no other counter changes.
- R5: Event counter n increments in each cycle that `evt_i[sel_n]` is high, provided counter n is enabled and the bank is not frozen.
- R6: An event counter that receives an event at its maximum value holds that value and sets its sticky overflow flag. It does not assert `irq_o`.
- R7: Writing a control word with the clear bit 0 zeroes that counter's count and overflow flag. An event counter's clear bit reads back as 1 afterwards. The cycle counter's clear bit reads back as 0, and the cycle counter stays at zero until a 1 is written to the clear bit.
- R8: A control write with enable 1 and clear 1 zeroes the count and the overflow flag, and counting starts in the next cycle. A write with enable 0 and clear 1 keeps the count.
- R9: `irq_o` is low whenever the cycle counter is disabled. Re-enabling the cycle counter with clear 1 removes the freeze.
- R10: Reads of unmapped or misaligned offsets return zero. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| evt_i | input | 256 | Event pulses, indexed by event code |
| irq_o | output | 1 | Cycle-counter overflow interrupt, level |

## Verification
The hardest states to reach are the two overflows. At full width they take billions of cycles, so the bench instantiates the bank with 8-bit counters. An event counter only saturates before the timebase wraps if software keeps restarting the cycle counter while a constant event line drives the event counter. The bench does exactly that. It then lets the timebase wrap on purpose and pulses events during the freeze to show that they are lost.

// File: rtl/memc_perf_pkg.sv
package memc_perf_pkg;
  localparam int DATA_W  = 32;
  localparam int SEL_W   = 8;
  localparam int NUM_EVT = 1 << SEL_W;
  localparam int OVF_B   = 0;
  localparam int CLR_B   = 1;
  localparam int EN_B    = 2;
  localparam int SEL_LSB = 24;
  localparam int CTRL_OFS = 'h00;
  localparam int CNT_OFS  = 'h20;

  function automatic logic [DATA_W-1:0] pack_ctrl(input logic [SEL_W-1:0] sel,
                                                  input logic en, input logic clr,
                                                  input logic ovf);
    pack_ctrl = {sel, 21'b0, en, clr, ovf};
  endfunction
endpackage

// File: rtl/memc_perf_ctr.sv
module memc_perf_ctr
  import memc_perf_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter bit IS_CYC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic             wr_clr_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             run_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             clr_o,
  output logic             ovf_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             en_q, clr_q, ovf_q;
  logic [SEL_W-1:0] sel_q;
  logic             act;

  assign act = en_q & clr_q & ~ovf_q & run_i & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      clr_q <= 1'b1;
      ovf_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_i) begin
      en_q  <= wr_en_i;
      sel_q <= IS_CYC ? '0 : wr_sel_i;
      // only the cycle counter keeps a written 0 in clear
      clr_q <= IS_CYC ? wr_clr_i : 1'b1;
      if (!wr_clr_i || wr_en_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end
    end else if (act) begin
      if (cnt_q == MAX) begin
        ovf_q <= 1'b1;
        cnt_q <= IS_CYC ? '0 : cnt_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;
  assign clr_o = clr_q;
  assign ovf_o = ovf_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/memc_perf_regif.sv
module memc_perf_regif
  import memc_perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  input  logic                              req_write_i,
  input  logic [ADDR_W-1:0]                 req_addr_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]    ctrl_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]     cnt_i,
  output logic [NUM_CNT-1:0]                ctrl_we_o,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic                              rvalid_o
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    ctrl_we_o = '0;
    rd_mux    = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (req_addr_i == ADDR_W'(CTRL_OFS + 4 * i)) begin
        ctrl_we_o[i] = req_valid_i & req_write_i;
        rd_mux       = ctrl_i[i];
      end
      if (req_addr_i == ADDR_W'(CNT_OFS + 4 * i))
        rd_mux = DATA_W'(cnt_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_valid_i & ~req_write_i;
      if (req_valid_i && !req_write_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/memc_perf_bank.sv
module memc_perf_bank
  import memc_perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_CNT-1:0][DATA_W-1:0] ctrl_w;
  logic [NUM_CNT-1:0][SEL_W-1:0]  sel_q;
  logic [NUM_CNT-1:0]             en_q, clr_q, ovf_q, hit, ctrl_we;
  logic                           run_all;
  logic                           unused_wdata;

  assign unused_wdata = ^req_wdata_i[SEL_LSB-1:EN_B+1] ^ req_wdata_i[OVF_B];

  // cycle counter is the bank's timebase: any stop of it freezes all
  assign run_all = en_q[0] & clr_q[0] & ~ovf_q[0];
  assign irq_o   = ovf_q[0] & en_q[0];

  memc_perf_regif #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regif_i (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i,
    .ctrl_i(ctrl_w), .cnt_i(cnt_q), .ctrl_we_o(ctrl_we), .rdata_o, .rvalid_o
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
    if (g == 0) begin : g_cyc
      assign hit[g] = 1'b1;
    end else begin : g_evt
      assign hit[g] = evt_i[sel_q[g]];
    end

    memc_perf_ctr #(.CNT_W(CNT_W), .IS_CYC(g == 0)) ctr_i (
      .clk_i, .rst_ni,
      .wr_i    (ctrl_we[g]),
      .wr_en_i (req_wdata_i[EN_B]),
      .wr_clr_i(req_wdata_i[CLR_B]),
      .wr_sel_i(req_wdata_i[SEL_LSB +: SEL_W]),
      .run_i   (run_all),
      .hit_i   (hit[g]),
      .cnt_o   (cnt_q[g]),
      .en_o    (en_q[g]),
      .clr_o   (clr_q[g]),
      .ovf_o   (ovf_q[g]),
      .sel_o   (sel_q[g])
    );

    assign ctrl_w[g] = pack_ctrl(sel_q[g], en_q[g], clr_q[g], ovf_q[g]);
  end
endmodule

// File: rtl/memc_perf_bank_chk.sv
module memc_perf_bank_chk
  import memc_perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_valid_i,
  input logic                          req_write_i,
  input logic [ADDR_W-1:0]             req_addr_i,
  input logic [DATA_W-1:0]             rdata_o,
  input logic                          irq_o,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CNT-1:0]            en_q,
  input logic [NUM_CNT-1:0]            clr_q,
  input logic [NUM_CNT-1:0]            ovf_q
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic wr_any, rd_req, mapped, run;
  assign wr_any = req_valid_i & req_write_i;
  assign rd_req = req_valid_i & ~req_write_i;
  assign run    = en_q[0] & clr_q[0] & ~ovf_q[0];

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < NUM_CNT; i++)
      if (req_addr_i == ADDR_W'(CTRL_OFS + 4 * i) || req_addr_i == ADDR_W'(CNT_OFS + 4 * i))
        mapped = 1'b1;
  end

  p_cyc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_any) |=> cnt_q[0] == CNT_W'($past(cnt_q[0]) + 1'b1));

  p_irq_on_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cnt_q[0]) == MAX);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !mapped) |=> rdata_o == '0);

  for (genvar g = 1; g < NUM_CNT; g++) begin : g_chk
    p_frozen_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_any) |=> $stable(cnt_q[g]));

    p_sat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q[g] && !wr_any) |=> (ovf_q[g] && cnt_q[g] == MAX));
  end
endmodule

bind memc_perf_bank memc_perf_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .cnt_q(cnt_q), .en_q(en_q), .clr_q(clr_q), .ovf_q(ovf_q)
);

// File: tb/memc_perf_bank_tb_top.sv
module memc_perf_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;
  logic [255:0] evt = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memc_perf_bank #(.NUM_CNT(4), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as the design returns them
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk("R1 unexpected read data", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int b, input int n);
    evt[b] = 1'b1;
    idle(n);
    evt[b] = 1'b0;
  endtask

  task automatic finish_run();
    idle(3);
    chk("R1 read queue drained", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    chk("R9 irq low after reset", 32'(irq), 32'h0);
    rd(8'h00, 32'h0000_0002, "R1 ctrl0 reset");
    rd(8'h20, 32'h0, "R1 count0 reset");
    rd(8'h04, 32'h0000_0002, "R1 ctrl1 reset");
    // unmapped space
    rd(8'h10, 32'h0, "R10 unmapped 0x10");
    rd(8'h44, 32'h0, "R10 unmapped 0x44");
    rd(8'h22, 32'h0, "R10 misaligned 0x22");
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0002, "R10 write to unmapped ignored");
    // cycle counter
    wr(8'h00, 32'hFF00_0006);
    rd(8'h20, 32'd0, "R2 cycle first");
    rd(8'h20, 32'd1, "R2 cycle second");
    idle(5);
    rd(8'h20, 32'd7, "R2 cycle after gap");
    rd(8'h00, 32'h0000_0006, "R2 cycle select reads zero");
    // event counter 2 on code 0x37
    wr(8'h08, 32'h3700_0006);
    pulse(8'h37, 3);
    rd(8'h28, 32'd3, "R5 burst of three");
    for (int k = 0; k < 4; k++) begin
      pulse(8'h37, 1);
      evt[8'h04] = 1'b1;
      idle(1);
      evt[8'h04] = 1'b0;
    end
    rd(8'h28, 32'd7, "R5 alternating pulses, other code ignored");
    rd(8'h08, 32'h3700_0006, "R1 ctrl2 layout");
    // disable keeps, enable+clear restarts
    wr(8'h08, 32'h3700_0002);
    pulse(8'h37, 4);
    rd(8'h28, 32'd7, "R8 disabled keeps count");
    wr(8'h08, 32'h3700_0006);
    rd(8'h28, 32'd0, "R8 enable write zeroes");
    pulse(8'h37, 2);
    rd(8'h28, 32'd2, "R8 counts after restart");
    // active-low clear on event counter
    wr(8'h08, 32'h3700_0004);
    rd(8'h08, 32'h3700_0006, "R7 event clear bit returns to one");
    rd(8'h28, 32'd0, "R7 event count zeroed");
    pulse(8'h37, 3);
    rd(8'h28, 32'd3, "R7 event resumes by itself");
    // active-low clear on cycle counter
    wr(8'h00, 32'h0000_0004);
    rd(8'h00, 32'h0000_0004, "R7 cycle clear bit stays zero");
    idle(5);
    rd(8'h20, 32'd0, "R7 cycle held at zero");
    pulse(8'h37, 2);
    rd(8'h28, 32'd3, "R4 frozen while cycle held in clear");
    wr(8'h00, 32'h0000_0006);
    rd(8'h20, 32'd0, "R7 cycle restart");
    rd(8'h20, 32'd1, "R7 cycle counting again");
    // event counter saturation, timebase restarted midway
    wr(8'h04, 32'h0500_0006);
    evt[8'h05] = 1'b1;
    idle(150);
    wr(8'h00, 32'h0000_0006);
    idle(150);
    evt[8'h05] = 1'b0;
    rd(8'h24, 32'd255, "R6 event counter saturates");
    rd(8'h04, 32'h0500_0007, "R6 sticky overflow flag");
    chk("R6 no irq from event overflow", 32'(irq), 32'h0);
    // timebase wrap
    idle(150);
    chk("R3 irq on cycle wrap", 32'(irq), 32'h1);
    rd(8'h20, 32'd0, "R3 cycle wrapped to zero");
    rd(8'h00, 32'h0000_0007, "R3 cycle overflow flag");
    pulse(8'h37, 4);
    rd(8'h28, 32'd3, "R4 events lost while frozen");
    // disable and restart timebase
    wr(8'h00, 32'h0000_0002);
    chk("R9 irq drops on disable", 32'(irq), 32'h0);
    rd(8'h00, 32'h0000_0003, "R9 disable keeps flag");
    wr(8'h00, 32'h0000_0006);
    rd(8'h00, 32'h0000_0006, "R9 restart clears flag");
    chk("R9 irq low after restart", 32'(irq), 32'h0);
    pulse(8'h37, 2);
    rd(8'h28, 32'd5, "R9 freeze released");
    done = 1'b1;
    finish_run();
  end
endmodule